// File: doc/BRIEF.md
# DRAM Row-Buffer Command Sequencer

This block sits between a request source and one DRAM channel. It takes one request at a time, a physical address plus a read/write flag, through a valid/ready handshake. It breaks the address into a row, a bank and a column. It picks the bank by XOR-ing the bank field of the address with the low bits of the row field. Addresses that would share a bank under plain page interleaving, because they differ only in their upper bits, therefore land in different banks. A whole page still stays inside one bank.

For every bank the sequencer remembers whether a row is open, and which row it is. From that record it classifies each request as a row hit, a miss to an idle bank, or a row conflict. It then issues the command sequence that class needs: a column access alone, an activate and then a column access, or a precharge, an activate and a column access. A parameterised cycle delay separates consecutive commands.

A policy input, sampled when a request is accepted, selects the precharge policy. Under open-page the row is left open after the access. Under close-page the bank is precharged straight after the column command. The access class is reported as a one-cycle pulse alongside the column command.

Top module: `dram_rowbuf_seq`

## Requirements
- R1: The address is `{row, bank_field, col}` with col in the low COL_W bits, bank_field in the next BANK_BITS bits and row in the upper ROW_W bits. The bank driven on `cmd_bank` is `bank_field XOR row[BANK_BITS-1:0]`; `cmd_row` equals the row field and `cmd_col` equals the col field.
- R2: After reset every bank holds no open row, so the first request to any bank is classed as a miss to an idle bank.
- R3: A request to the row already open in its bank is a hit (status code 0). It produces only a column command (`cmd_code` 2), in the cycle after acceptance.
- R4: A request to a bank with no open row is a miss (status code 1). It produces an activate (`cmd_code` 1) in the cycle after acceptance, then a column command T_ACT cycles later.
- R5: A request to a bank with a different row open is a conflict (status code 2). It produces a precharge (`cmd_code` 0) in the cycle after acceptance, an activate T_PRE cycles later, and a column command T_ACT cycles after that.
- R6: Under the open-page policy (`close_page` = 0), the activated row stays open after the access, and a later request to the same row is a hit.
- R7: Under the close-page policy (`close_page` = 1), a precharge to the same bank follows the column command after T_COL cycles, and the bank then holds no open row.
- R8: `req_ready` is high only while no request is in progress. It returns high T_COL cycles after the column command under open-page, or T_PRE cycles after the closing precharge under close-page.
- R9: `done_valid` pulses exactly in the cycle of the column command. In that cycle `done_status` carries the access class and `cmd_write` carries the request's read/write flag.
- R10: The 2^BANK_BITS pages that share one row field fall into 2^BANK_BITS distinct banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid is high |
| req_addr | input | ROW_W+BANK_BITS+COL_W | Physical address |
| req_write | input | 1 | 1 = write, 0 = read |
| close_page | input | 1 | Precharge policy for this request: 1 = close-page, 0 = open-page |
| cmd_valid | output | 1 | A DRAM command is issued this cycle |
| cmd_code | output | 2 | 0 precharge, 1 activate, 2 column access |
| cmd_bank | output | BANK_BITS | Permuted bank index |
| cmd_row | output | ROW_W | Row address |
| cmd_col | output | COL_W | Column address |
| cmd_write | output | 1 | Read/write flag of the current request |
| done_valid | output | 1 | Access class is valid (column command cycle) |
| done_status | output | 2 | 0 hit, 1 miss to idle bank, 2 conflict |

## Verification
Several rules are checked by assertions on every cycle:
- the handshake stays closed while commands are going out;
- commands are never adjacent;
- an activate never targets a bank that already has an open row, and a precharge never targets a bank that has none;
- every column command addresses the row that is open in its bank;
- a hit's column command immediately follows acceptance.

Only the bench's scenarios can show the remaining behaviour: the exact cycle spacing between commands, the XOR bank permutation, how each bank's state evolves across mixed open-page and close-page sequences, and the spread of neighbouring pages over all banks. The bench checks these by comparing every port against a behavioural model on every cycle.

// File: rtl/drs_pkg.sv
package drs_pkg;

    typedef enum logic [1:0] {
        CMD_PRE = 2'd0,
        CMD_ACT = 2'd1,
        CMD_COL = 2'd2
    } cmd_e;

    typedef enum logic [1:0] {
        ACC_HIT      = 2'd0,
        ACC_MISS     = 2'd1,
        ACC_CONFLICT = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_PRE,
        FS_ACT,
        FS_COL,
        FS_WAIT,
        FS_CLOSE
    } fsm_e;

    function automatic acc_e classify(input logic is_open, input logic same_row);
        if (!is_open)
            return ACC_MISS;
        else if (same_row)
            return ACC_HIT;
        else
            return ACC_CONFLICT;
    endfunction

    function automatic fsm_e entry_state(input acc_e cls);
        case (cls)
            ACC_HIT:  return FS_COL;
            ACC_MISS: return FS_ACT;
            default:  return FS_PRE;
        endcase
    endfunction

endpackage

// File: rtl/drs_addr_map.sv
module drs_addr_map #(
    parameter int ROW_W     = 8,
    parameter int BANK_BITS = 2,
    parameter int COL_W     = 6,
    localparam int ADDR_W   = ROW_W + BANK_BITS + COL_W
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [BANK_BITS-1:0] bank,
    output logic [ROW_W-1:0]     row,
    output logic [COL_W-1:0]     col
);
    logic [BANK_BITS-1:0] bank_field;
    logic [BANK_BITS-1:0] perm_bits;

    assign col        = addr[COL_W-1:0];
    assign bank_field = addr[COL_W +: BANK_BITS];
    assign row        = addr[COL_W+BANK_BITS +: ROW_W];

    generate
        if (ROW_W >= BANK_BITS) begin : g_perm
            assign perm_bits = row[BANK_BITS-1:0];
        end else begin : g_perm_short
            assign perm_bits = BANK_BITS'(row);
        end
    endgenerate

    assign bank = bank_field ^ perm_bits;
endmodule

// File: rtl/drs_bank_table.sv
module drs_bank_table #(
    parameter int BANK_BITS = 2,
    parameter int ROW_W     = 8,
    localparam int NBANK    = 1 << BANK_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BANK_BITS-1:0] look_bank,
    output logic                 look_open,
    output logic [ROW_W-1:0]     look_row,
    input  logic                 set_en,
    input  logic [BANK_BITS-1:0] set_bank,
    input  logic [ROW_W-1:0]     set_row,
    input  logic                 clr_en,
    input  logic [BANK_BITS-1:0] clr_bank
);
    logic [NBANK-1:0] open_q;
    logic [ROW_W-1:0] row_q [NBANK];

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            always_ff @(posedge clk) begin
                if (rst) begin
                    open_q[b] <= 1'b0;
                    row_q[b]  <= '0;
                end else if (set_en && set_bank == BANK_BITS'(b)) begin
                    open_q[b] <= 1'b1;
                    row_q[b]  <= set_row;
                end else if (clr_en && clr_bank == BANK_BITS'(b)) begin
                    open_q[b] <= 1'b0;
                end
            end
        end
    endgenerate

    assign look_open = open_q[look_bank];
    assign look_row  = row_q[look_bank];

    // R4: an activate only targets a bank that holds no open row
    a_r4_act_on_idle_bank: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !open_q[set_bank]);

    // R5: a precharge only targets a bank that has an open row
    a_r5_pre_on_open_bank: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> open_q[clr_bank]);
endmodule

// File: rtl/drs_cmd_fsm.sv
module drs_cmd_fsm
    import drs_pkg::*;
#(
    parameter int T_PRE = 3,
    parameter int T_ACT = 3,
    parameter int T_COL = 2,
    localparam int T_MAX = (T_PRE > T_ACT) ? ((T_PRE > T_COL) ? T_PRE : T_COL)
                                           : ((T_ACT > T_COL) ? T_ACT : T_COL),
    localparam int CNT_W = $clog2(T_MAX + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  fsm_e first_st,
    input  logic close_pol,
    output logic idle,
    output logic cmd_valid,
    output cmd_e cmd_code
);
    fsm_e             state_q, resume_q;
    logic [CNT_W-1:0] cnt_q;

    assign idle = (state_q == FS_IDLE);

    always_comb begin
        cmd_valid = 1'b1;
        cmd_code  = CMD_PRE;
        case (state_q)
            FS_PRE, FS_CLOSE: cmd_code = CMD_PRE;
            FS_ACT:           cmd_code = CMD_ACT;
            FS_COL:           cmd_code = CMD_COL;
            default:          cmd_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= FS_IDLE;
            resume_q <= FS_IDLE;
            cnt_q    <= '0;
        end else begin
            case (state_q)
                FS_IDLE: if (start) state_q <= first_st;
                FS_PRE: begin
                    state_q  <= FS_WAIT;
                    resume_q <= FS_ACT;
                    cnt_q    <= CNT_W'(T_PRE - 1);
                end
                FS_ACT: begin
                    state_q  <= FS_WAIT;
                    resume_q <= FS_COL;
                    cnt_q    <= CNT_W'(T_ACT - 1);
                end
                FS_COL: begin
                    state_q  <= FS_WAIT;
                    resume_q <= close_pol ? FS_CLOSE : FS_IDLE;
                    cnt_q    <= CNT_W'(T_COL - 1);
                end
                FS_CLOSE: begin
                    state_q  <= FS_WAIT;
                    resume_q <= FS_IDLE;
                    cnt_q    <= CNT_W'(T_PRE - 1);
                end
                FS_WAIT: begin
                    if (cnt_q == CNT_W'(1)) state_q <= resume_q;
                    else                    cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    // R8: every command is followed by at least one quiet cycle (delays >= 2)
    a_r8_cmd_spacing: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R8: the wait counter never idles at zero while waiting
    a_r8_wait_nonzero: assert property (@(posedge clk) disable iff (rst)
        (state_q == FS_WAIT) |-> (cnt_q != '0));
endmodule

// File: rtl/dram_rowbuf_seq.sv
module dram_rowbuf_seq
    import drs_pkg::*;
#(
    parameter int ROW_W     = 8,
    parameter int BANK_BITS = 2,
    parameter int COL_W     = 6,
    parameter int T_PRE     = 3,
    parameter int T_ACT     = 3,
    parameter int T_COL     = 2,
    localparam int ADDR_W   = ROW_W + BANK_BITS + COL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    input  logic                 close_page,
    output logic                 cmd_valid,
    output logic [1:0]           cmd_code,
    output logic [BANK_BITS-1:0] cmd_bank,
    output logic [ROW_W-1:0]     cmd_row,
    output logic [COL_W-1:0]     cmd_col,
    output logic                 cmd_write,
    output logic                 done_valid,
    output logic [1:0]           done_status
);
    logic [BANK_BITS-1:0] m_bank, q_bank, look_bank;
    logic [ROW_W-1:0]     m_row, q_row, look_row;
    logic [COL_W-1:0]     m_col, q_col;
    logic                 q_write, q_close, look_open, fsm_idle, accept, fsm_cmd_valid;
    acc_e                 cls, q_status;
    cmd_e                 fsm_code;

    drs_addr_map #(.ROW_W(ROW_W), .BANK_BITS(BANK_BITS), .COL_W(COL_W)) map_i (
        .addr(req_addr), .bank(m_bank), .row(m_row), .col(m_col)
    );

    assign look_bank = fsm_idle ? m_bank : q_bank;

    drs_bank_table #(.BANK_BITS(BANK_BITS), .ROW_W(ROW_W)) table_i (
        .clk(clk), .rst(rst),
        .look_bank(look_bank), .look_open(look_open), .look_row(look_row),
        .set_en(fsm_cmd_valid && fsm_code == CMD_ACT), .set_bank(q_bank), .set_row(q_row),
        .clr_en(fsm_cmd_valid && fsm_code == CMD_PRE), .clr_bank(q_bank)
    );

    assign cls       = classify(look_open, look_row == m_row);
    assign req_ready = fsm_idle;
    assign accept    = req_valid && fsm_idle;

    drs_cmd_fsm #(.T_PRE(T_PRE), .T_ACT(T_ACT), .T_COL(T_COL)) fsm_i (
        .clk(clk), .rst(rst), .start(accept), .first_st(entry_state(cls)),
        .close_pol(q_close), .idle(fsm_idle), .cmd_valid(fsm_cmd_valid), .cmd_code(fsm_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q_bank   <= '0;
            q_row    <= '0;
            q_col    <= '0;
            q_write  <= 1'b0;
            q_close  <= 1'b0;
            q_status <= ACC_HIT;
        end else if (accept) begin
            q_bank   <= m_bank;
            q_row    <= m_row;
            q_col    <= m_col;
            q_write  <= req_write;
            q_close  <= close_page;
            q_status <= cls;
        end
    end

    assign cmd_valid   = fsm_cmd_valid;
    assign cmd_code    = fsm_code;
    assign cmd_bank    = q_bank;
    assign cmd_row     = q_row;
    assign cmd_col     = q_col;
    assign cmd_write   = q_write;
    assign done_valid  = fsm_cmd_valid && fsm_code == CMD_COL;
    assign done_status = q_status;

    // R8: no request can be taken while a command is on the bus
    a_r8_ready_quiet: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !req_ready);

    // R3: a column command always addresses the row open in its bank
    a_r3_col_open_row: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_COL) |-> (look_open && look_row == cmd_row));

    // R3: a hit's column command follows acceptance in the very next cycle
    a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_status == ACC_HIT) |-> $past(req_valid && req_ready));

    // R9: the status pulse never appears without a column command
    a_r9_done_on_col: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (cmd_valid && cmd_code == CMD_COL));
endmodule

// File: tb/dram_rowbuf_seq_tb_top.sv
module dram_rowbuf_seq_tb_top;
    localparam int ROW_W = 8, BB = 2, COL_W = 6;
    localparam int TP = 3, TA = 3, TC = 2;
    localparam int NB = 1 << BB;
    localparam int AW = ROW_W + BB + COL_W;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, close_page = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_ready, cmd_valid, cmd_write, done_valid;
    logic [1:0] cmd_code, done_status;
    logic [BB-1:0] cmd_bank;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;

    int vectors = 0, errors = 0;
    bit m_open [NB];
    int m_row  [NB];

    always #5 clk = ~clk;

    dram_rowbuf_seq #(.ROW_W(ROW_W), .BANK_BITS(BB), .COL_W(COL_W),
                      .T_PRE(TP), .T_ACT(TA), .T_COL(TC)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .close_page(close_page),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_write(cmd_write),
        .done_valid(done_valid), .done_status(done_status)
    );

    // One request; every cycle until idle is compared against the model.
    task automatic run_req(input int row, input int bf, input int col,
                           input bit wr, input bit cls, input string tag);
        int bank, st, pre_o, act_o, col_o, clo_o, idle_o;
        bank = bf ^ (row % NB);
        if (!m_open[bank])           st = 1;
        else if (m_row[bank] == row) st = 0;
        else                         st = 2;
        pre_o = -1; act_o = -1; clo_o = -1;
        if (st == 0) col_o = 1;
        else if (st == 1) begin act_o = 1; col_o = 1 + TA; end
        else begin pre_o = 1; act_o = 1 + TP; col_o = act_o + TA; end
        if (cls) begin clo_o = col_o + TC; idle_o = clo_o + TP; end
        else idle_o = col_o + TC;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_addr   = AW'((row << (BB + COL_W)) | (bf << COL_W) | col);
        req_write  = wr;
        close_page = cls;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 1; t <= idle_o; t++) begin
            logic       ev, ed, er;
            logic [1:0] ec;
            ev = 1'b0; ec = 2'd0; ed = 1'b0; er = (t == idle_o);
            if (t == pre_o || t == clo_o) begin ev = 1'b1; ec = 2'd0; end
            if (t == act_o) begin ev = 1'b1; ec = 2'd1; end
            if (t == col_o) begin ev = 1'b1; ec = 2'd2; ed = 1'b1; end
            vectors++;
            if (cmd_valid !== ev || req_ready !== er || done_valid !== ed ||
                (ev && (cmd_code !== ec || cmd_bank !== BB'(bank) ||
                        cmd_row !== ROW_W'(row) || cmd_col !== COL_W'(col))) ||
                (ed && (done_status !== 2'(st) || cmd_write !== wr))) begin
                errors++;
                $display("FAIL %s t=%0d got v=%0b code=%0d bank=%0d row=%0d col=%0d rdy=%0b done=%0b st=%0d wr=%0b exp v=%0b code=%0d bank=%0d row=%0d col=%0d rdy=%0b done=%0b st=%0d wr=%0b",
                         tag, t, cmd_valid, cmd_code, cmd_bank, cmd_row, cmd_col, req_ready,
                         done_valid, done_status, cmd_write, ev, ec, bank, row, col, er, ed, st, wr);
            end
            if (t < idle_o) @(negedge clk);
        end
        if (st != 0) begin m_open[bank] = 1'b1; m_row[bank] = row; end
        if (cls) m_open[bank] = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog expired: sequencer never returned to idle");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin m_open[b] = 1'b0; m_row[b] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        vectors++;
        if (req_ready !== 1'b1 || cmd_valid !== 1'b0 || done_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2 reset state got rdy=%0b v=%0b done=%0b exp 1 0 0",
                     req_ready, cmd_valid, done_valid);
        end
        run_req(5, 1, 3, 1'b0, 1'b0, "R2 R4 first access miss");
        run_req(5, 1, 9, 1'b1, 1'b0, "R3 R6 hit on open row");
        run_req(9, 1, 0, 1'b0, 1'b0, "R5 conflict same bank");
        run_req(6, 3, 4, 1'b1, 1'b0, "R1 R4 xor bank miss");
        run_req(7, 2, 5, 1'b0, 1'b0, "R1 R5 xor alias conflict");
        for (int bf = 0; bf < NB; bf++)
            run_req(13, bf, bf, bf[0], 1'b0, "R10 page spread");
        run_req(13, 1, 2, 1'b1, 1'b1, "R7 R9 close-page hit then precharge");
        run_req(13, 1, 2, 1'b0, 1'b1, "R7 R8 close-page leaves bank idle");
        run_req(13, 1, 7, 1'b0, 1'b0, "R4 open-page after close");
        run_req(13, 1, 8, 1'b1, 1'b0, "R6 R9 hit after reopen");
        run_req(200, 3, 63, 1'b0, 1'b1, "R1 R7 boundary address close");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule